// File: doc/BRIEF.md
# Strobed-Bus Dual-Color LED Controller

This block drives six two-color (blue/red) indicator LEDs: one front LED and five drive-bay LEDs. A host configures it over a narrow parallel bus made of a 3-bit address, a 3-bit data value and one write strobe. The bus needs no clock relation to the block. All three bus inputs pass through two-flop synchronizers, and a register is written when the synchronized strobe rises. Eight 3-bit registers hold the front mode, the front brightness, a brightness shared by all bay LEDs, and one mode per bay.

Each 3-bit mode code selects a steady color, off, or a timed blink pattern built from 0.5 s ticks. Bay LEDs have a mode that follows a per-bay disk activity input: the LED is blue while idle and goes dark for a stretched period after each activity pulse. Brightness is applied by pulse-width modulation over seven slots and gated with the pattern. Tick length, PWM slot length and activity stretch length are parameters. The defaults suit a 125 MHz clock: 0.5 s ticks, a PWM slot of 16 µs and a 50 ms stretch.

Top module: `led_strobe_ctrl`

## Requirements
- R1: A register is written only when the synchronized strobe changes from 0 to 1. The write takes the synchronized address and data, and its effect appears at the outputs after the third rising clock edge following the input change. A strobe held high and a falling strobe write nothing, even if address or data change in the meantime.
- R2: Register map: 0 front mode, 1 front brightness, 2 bay brightness (shared by all bays), 3+i mode of bay i for i = 0..4. The front brightness does not affect bay LEDs.
- R3: While reset is active, every register clears to 0. After reset every output is low.
- R4: Brightness level L (0..7) turns the LED on in exactly L of every 7 consecutive PWM slots. Level 0 keeps the LED dark and level 7 keeps it steadily on.
- R5: Front mode codes, with t the time since the mode write in 0.5 s ticks: 0 off; 1 blue; 2 red; 3 blue when t mod 4 < 2, else off; 4 red when t mod 4 < 2, else off; 5 blue when t mod 6 < 5, else red; 6 blue when t mod 4 < 2, else red; 7 blue when t mod 6 = 0, else off.
- R6: Bay mode codes 0 and 2..6 behave as the front codes. Bay code 7 is steady blue, and bay code 1 is activity mode (R7).
- R7: In activity mode a bay LED is blue when idle. A pulse on its activity input turns it off for HOLD_CYCLES clock cycles, starting at the third rising edge after the pulse; a pulse during the dark period restarts the period.
- R8: Every write to a mode register restarts that LED's sequence at tick 0, even when the code does not change, and the tick boundaries then fall every TICK_CYCLES cycles from the write.
- R9: No LED ever has blue and red on at the same time.
- R10: In every bay mode other than activity mode, the activity input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register address from the host bus |
| bus_data | input | 3 | Register value from the host bus |
| bus_stb | input | 1 | Write strobe; its rising edge commits a write |
| sata_act | input | 5 | Per-bay disk activity pulses |
| front_blue | output | 1 | Front LED blue drive |
| front_red | output | 1 | Front LED red drive |
| bay_blue | output | 5 | Bay LED blue drives, bit i for bay i |
| bay_red | output | 5 | Bay LED red drives, bit i for bay i |

## Verification
A wrong register value or a misrouted write appears at the affected LED within three cycles of the strobe, as a wrong color or a wrong duty. A phase counter that slips or wraps at the wrong count shows up at the first tick boundary. A wrap error also appears by the twelfth tick, because the bench checks sequences past one full wrap against absolute time. PWM slot errors change the on-count inside any seven-slot window. A stretch counter fault changes the length of the dark period that follows an activity pulse by a cycle-exact amount.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

    localparam int CODE_W    = 3;
    localparam int NUM_REGS  = 1 << CODE_W;
    localparam int REG_FMODE = 0;
    localparam int REG_FLVL  = 1;
    localparam int REG_BLVL  = 2;
    localparam int BAY_BASE  = 3;
    localparam int NUM_BAYS  = NUM_REGS - BAY_BASE;
    localparam int PHASES    = 12;   // common multiple of the 4- and 6-tick cycles
    localparam int PH_W      = 4;
    localparam int PWM_SLOTS = 7;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [PH_W-1:0]   phase_t;

    // Returns {blue, red} for a mode code at a phase.
    function automatic logic [1:0] pattern_bits(code_t code, phase_t ph,
                                                logic is_bay, logic busy);
        logic [1:0] r;
        logic       first_half;
        phase_t     m6;
        first_half = (ph[1:0] < 2'd2);
        m6 = (ph >= phase_t'(6)) ? ph - phase_t'(6) : ph;
        case (code)
            3'd0: r = 2'b00;
            3'd1: r = is_bay ? {~busy, 1'b0} : 2'b10;
            3'd2: r = 2'b01;
            3'd3: r = first_half ? 2'b10 : 2'b00;
            3'd4: r = first_half ? 2'b01 : 2'b00;
            3'd5: r = (m6 < phase_t'(5)) ? 2'b10 : 2'b01;
            3'd6: r = first_half ? 2'b10 : 2'b01;
            default: r = is_bay ? 2'b10 : ((m6 == '0) ? 2'b10 : 2'b00);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/led_regfile.sv
module led_regfile
    import led_ctrl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CODE_W-1:0]             addr_in,
    input  logic [CODE_W-1:0]             data_in,
    input  logic                          stb_in,
    output logic [NUM_REGS-1:0][CODE_W-1:0] regs_o,
    output logic                          wr_o,
    output logic [CODE_W-1:0]             wr_addr_o
);

    typedef struct packed {
        logic [CODE_W-1:0]               addr_s1;
        logic [CODE_W-1:0]               addr_s2;
        logic [CODE_W-1:0]               data_s1;
        logic [CODE_W-1:0]               data_s2;
        logic                            stb_s1;
        logic                            stb_s2;
        logic                            stb_prev;
        logic [NUM_REGS-1:0][CODE_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      wr_edge;

    assign wr_edge = st_q.stb_s2 & ~st_q.stb_prev;

    always_comb begin
        st_d          = st_q;
        st_d.addr_s1  = addr_in;
        st_d.addr_s2  = st_q.addr_s1;
        st_d.data_s1  = data_in;
        st_d.data_s2  = st_q.data_s1;
        st_d.stb_s1   = stb_in;
        st_d.stb_s2   = st_q.stb_s1;
        st_d.stb_prev = st_q.stb_s2;
        if (wr_edge) begin
            st_d.regs[st_q.addr_s2] = st_q.data_s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o    = st_q.regs;
    assign wr_o      = wr_edge;
    assign wr_addr_o = st_q.addr_s2;

    assert_regs_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_edge |=> $stable(st_q.regs));

    assert_commit_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_edge |=> (st_q.regs[$past(st_q.addr_s2)] == $past(st_q.data_s2)));

endmodule

// File: rtl/led_phase_timer.sv
module led_phase_timer
    import led_ctrl_pkg::*;
#(
    parameter int TICK_CYCLES = 62_500_000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    output phase_t phase_o
);

    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);
    localparam phase_t PH_LAST = phase_t'(PHASES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        phase_t           phase;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt   = '0;
            st_d.phase = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt   = '0;
            st_d.phase = (st_q.phase == PH_LAST) ? '0 : st_q.phase + phase_t'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= PH_LAST);

    assert_phase_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && st_q.cnt != CNT_LAST) |=> $stable(st_q.phase));

    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.phase == '0));

endmodule

// File: rtl/led_pwm_slot.sv
module led_pwm_slot
    import led_ctrl_pkg::*;
#(
    parameter int SLOT_CYCLES = 2_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] slot_o
);

    localparam int DIV_W = $clog2(SLOT_CYCLES + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOT_CYCLES - 1);
    localparam logic [2:0] SLOT_LAST = 3'(PWM_SLOTS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [2:0]       slot;
    } pw_state_t;

    pw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div == DIV_LAST) begin
            st_d.div  = '0;
            st_d.slot = (st_q.slot == SLOT_LAST) ? 3'd0 : st_q.slot + 3'd1;
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;

    assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= SLOT_LAST);

endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
    parameter int HOLD_CYCLES = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_in,
    output logic busy_o
);

    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic              act_s1;
        logic              act_s2;
        logic [HOLD_W-1:0] hold;
    } as_state_t;

    as_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.act_s1 = act_in;
        st_d.act_s2 = st_q.act_s1;
        if (st_q.act_s2) begin
            st_d.hold = HOLD_W'(HOLD_CYCLES);
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.hold != '0);

    assert_idle_without_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !st_q.act_s2) |=> !busy_o);

endmodule

// File: rtl/led_strobe_ctrl.sv
module led_strobe_ctrl
    import led_ctrl_pkg::*;
#(
    parameter int TICK_CYCLES = 62_500_000,
    parameter int SLOT_CYCLES = 2_000,
    parameter int HOLD_CYCLES = 6_250_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic [2:0]          bus_data,
    input  logic                bus_stb,
    input  logic [NUM_BAYS-1:0] sata_act,
    output logic                front_blue,
    output logic                front_red,
    output logic [NUM_BAYS-1:0] bay_blue,
    output logic [NUM_BAYS-1:0] bay_red
);

    logic [NUM_REGS-1:0][CODE_W-1:0] regs;
    logic                            wr;
    logic [CODE_W-1:0]               wr_addr;
    logic [2:0]                      slot;
    phase_t                          front_phase;
    logic                            front_pwm;
    logic                            bay_pwm;
    logic [1:0]                      front_pat;

    led_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (bus_addr),
        .data_in   (bus_data),
        .stb_in    (bus_stb),
        .regs_o    (regs),
        .wr_o      (wr),
        .wr_addr_o (wr_addr)
    );

    led_pwm_slot #(.SLOT_CYCLES(SLOT_CYCLES)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot)
    );

    led_phase_timer #(.TICK_CYCLES(TICK_CYCLES)) u_front_tm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr && wr_addr == CODE_W'(REG_FMODE)),
        .phase_o (front_phase)
    );

    always_comb begin
        front_pwm  = (slot < regs[REG_FLVL]);
        bay_pwm    = (slot < regs[REG_BLVL]);
        front_pat  = pattern_bits(regs[REG_FMODE], front_phase, 1'b0, 1'b0);
        front_blue = front_pat[1] & front_pwm;
        front_red  = front_pat[0] & front_pwm;
    end

    for (genvar g = 0; g < NUM_BAYS; g++) begin : g_bay
        phase_t     phase;
        logic       busy;
        logic [1:0] pat;

        led_phase_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tm (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (wr && wr_addr == CODE_W'(BAY_BASE + g)),
            .phase_o (phase)
        );

        led_act_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_act (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_in (sata_act[g]),
            .busy_o (busy)
        );

        always_comb begin
            pat         = pattern_bits(regs[BAY_BASE + g], phase, 1'b1, busy);
            bay_blue[g] = pat[1] & bay_pwm;
            bay_red[g]  = pat[0] & bay_pwm;
        end

        assert_bay_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(bay_blue[g] && bay_red[g]));

        assert_bay_dark_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[BAY_BASE + g] == 3'd1 && busy) |-> (!bay_blue[g] && !bay_red[g]));
    end

    assert_front_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(front_blue && front_red));

    assert_front_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[REG_FMODE] == 3'd0 || regs[REG_FLVL] == 3'd0) |-> (!front_blue && !front_red));

endmodule

// File: tb/sim_led_strobe_ctrl.sv
module sim_led_strobe_ctrl;

    localparam int T  = 8;
    localparam int S  = 5;
    localparam int NB = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    addr;
    logic [2:0]    data;
    logic          stb;
    logic [NB-1:0] act;
    logic          front_blue, front_red;
    logic [NB-1:0] bay_blue, bay_red;

    int checks   = 0;
    int failures = 0;
    int both_on  = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    led_strobe_ctrl #(.TICK_CYCLES(T), .SLOT_CYCLES(1), .HOLD_CYCLES(S)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (addr),
        .bus_data   (data),
        .bus_stb    (stb),
        .sata_act   (act),
        .front_blue (front_blue),
        .front_red  (front_red),
        .bay_blue   (bay_blue),
        .bay_red    (bay_red)
    );

    always @(negedge clk)
        if (rst_n === 1'b1 && ((front_blue && front_red) || (|(bay_blue & bay_red))))
            both_on++;

    task automatic chk(bit ok, string req, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    // Expected {blue, red} from time since the write, in ms.
    function automatic logic [1:0] ref_bits(int code, int ms, bit bay, bit busy);
        case (code)
            0: return 2'b00;
            1: return (bay && busy) ? 2'b00 : 2'b10;
            2: return 2'b01;
            3: return (ms % 2000 < 1000) ? 2'b10 : 2'b00;
            4: return (ms % 2000 < 1000) ? 2'b01 : 2'b00;
            5: return (ms % 3000 < 2500) ? 2'b10 : 2'b01;
            6: return (ms % 2000 < 1000) ? 2'b10 : 2'b01;
            default: return bay ? 2'b10 : ((ms % 3000 < 500) ? 2'b10 : 2'b00);
        endcase
    endfunction

    // Ends at the negedge of the first cycle after the commit edge.
    task automatic wr(int a, int d);
        @(negedge clk);
        addr = a[2:0];
        data = d[2:0];
        stb  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic run_pattern(int a, int code, bit bay, int idx, string req);
        int bad = 0;
        int got_f = 0;
        int exp_f = 0;
        logic [1:0] got;
        logic [1:0] exp;
        wr(a, code);
        for (int j = 0; j < 14 * T; j++) begin
            if (j > 0) @(negedge clk);
            exp = ref_bits(code, (j / T) * 500, bay, 1'b0);
            got = bay ? {bay_blue[idx], bay_red[idx]} : {front_blue, front_red};
            if (got !== exp) begin
                if (bad == 0) begin
                    got_f = int'(got);
                    exp_f = int'(exp);
                end
                bad++;
            end
        end
        chk(bad == 0, req, got_f, exp_f);
    endtask

    task automatic count_on(output int fcnt, output int bcnt, input int bay);
        fcnt = 0;
        bcnt = 0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            fcnt += int'(front_blue);
            bcnt += int'(bay_blue[bay]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int fc;
        int bc;
        int bad;
        rst_n = 1'b0;
        addr  = '0;
        data  = '0;
        stb   = 1'b0;
        act   = '0;
        repeat (5) @(negedge clk);
        chk({front_blue, front_red, bay_blue, bay_red} == '0, "R3 in reset",
            int'({front_blue, front_red, bay_blue, bay_red}), 0);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if ({front_blue, front_red, bay_blue, bay_red} != '0) bad++;
        end
        chk(bad == 0, "R3 after reset", bad, 0);

        wr(1, 7);
        wr(2, 7);

        // R1: held strobe and falling strobe write nothing
        @(negedge clk);
        addr = 3'd0; data = 3'd2; stb = 1'b1;
        repeat (4) @(negedge clk);
        chk(front_red === 1'b1, "R1 write on rising strobe", int'(front_red), 1);
        data = 3'd1;
        repeat (6) @(negedge clk);
        chk(front_red === 1'b1 && front_blue === 1'b0, "R1 held strobe",
            int'({front_blue, front_red}), 1);
        stb = 1'b0;
        repeat (6) @(negedge clk);
        chk(front_red === 1'b1 && front_blue === 1'b0, "R1 falling strobe",
            int'({front_blue, front_red}), 1);
        // R1: latency of three edges
        stb = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(front_blue === 1'b0, "R1 not before third edge", int'(front_blue), 0);
        @(posedge clk);
        @(negedge clk);
        chk(front_blue === 1'b1, "R1 at third edge", int'(front_blue), 1);
        stb = 1'b0;
        repeat (3) @(negedge clk);

        for (int c = 0; c < 8; c++) run_pattern(0, c, 1'b0, 0, "R5 front code");

        // R8: rewriting the same code mid-sequence restarts it
        wr(0, 5);
        repeat (13) @(negedge clk);
        run_pattern(0, 5, 1'b0, 0, "R8 restart same code");
        wr(0, 3);
        repeat (3 * T + 2) @(negedge clk);
        run_pattern(0, 7, 1'b0, 0, "R8 restart new code");

        for (int b = 0; b < NB; b++)
            for (int c = 0; c < 8; c++)
                if (c != 1) run_pattern(3 + b, c, 1'b1, b, "R6 bay code");

        // R7: activity stretch on bay 0
        wr(3, 1);
        repeat (4) @(negedge clk);
        act[0] = 1'b1;
        bad = 0;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            act[0] = 1'b0;
            if ({bay_blue[0], bay_red[0]} !== ((k >= 3 && k <= S + 2) ? 2'b00 : 2'b10)) bad++;
        end
        chk(bad == 0, "R7 stretched dark period", bad, 0);

        // R7: retrigger during dark period
        act[0] = 1'b1;
        @(negedge clk);
        act[0] = 1'b0;
        repeat (4) @(negedge clk);
        act[0] = 1'b1;
        bad = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            act[0] = 1'b0;
            if (bay_blue[0] !== ((k <= S + 2) ? 1'b0 : 1'b1)) bad++;
        end
        chk(bad == 0, "R7 retrigger", bad, 0);

        // R10: activity ignored in other modes
        wr(4, 7);
        wr(5, 2);
        repeat (2) @(negedge clk);
        act[1] = 1'b1;
        act[2] = 1'b1;
        bad = 0;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            act[1] = 1'b0;
            act[2] = 1'b0;
            if (bay_blue[1] !== 1'b1 || bay_red[2] !== 1'b1) bad++;
        end
        chk(bad == 0, "R10 activity ignored", bad, 0);

        // R4: brightness sweep
        wr(0, 1);
        wr(5, 7);
        for (int l = 0; l < 8; l++) begin
            wr(1, l);
            count_on(fc, bc, 2);
            chk(fc == l, "R4 front level", fc, l);
            chk(bc == 7, "R2 front level leaves bays", bc, 7);
        end
        for (int l = 0; l < 8; l++) begin
            wr(2, l);
            count_on(fc, bc, 2);
            chk(bc == l, "R4 bay level", bc, l);
            chk(fc == 7, "R2 bay level leaves front", fc, 7);
        end

        // R2: power-up style configuration
        wr(5, 0);
        wr(0, 1);
        wr(1, 3);
        wr(3, 1);
        wr(4, 1);
        wr(2, 3);
        count_on(fc, bc, 0);
        chk(fc == 3, "R2 front at level 3", fc, 3);
        chk(bc == 3, "R2 bay0 at level 3", bc, 3);
        count_on(fc, bc, 1);
        chk(bc == 3, "R2 bay1 at level 3", bc, 3);
        count_on(fc, bc, 2);
        chk(bc == 0, "R2 bay2 off", bc, 0);

        chk(both_on == 0, "R9 blue and red together", both_on, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule